// File: doc/BRIEF.md
# Passive LCD Scan Timing Generator

This block produces every timing signal a passive-matrix LCD module needs from its controller. It clocks 4-bit column data into the column drivers with a shift clock, hands the column-driver enable chain on every 16th shift clock, closes each line with a latch pulse, marks the last line of each frame with a scan start pulse, toggles an AC-drive signal at frame boundaries and drives a display-enable output that blanks the panel in sleep. Pixel nibbles come from an upstream fetch unit through a one-cycle request strobe.

Geometry is set by three inputs: active characters per row, total characters per row (active part plus horizontal retrace) and lines per frame. One character is 8 pixels wide, so it takes two shift clocks and eight input clocks. The configuration must be held steady while `disp_on` is high and must satisfy 1 <= chars < total and lines >= 2. The asynchronous reset is released synchronously inside the block.

A timing position counts input clocks from the first rising edge at which `disp_on` is sampled high (position 0). Within a line, position q splits into slot s = q/4 and phase ph = q mod 4; slot s is active when s < 2*chars.

Top module: `lcd_scan_timer`

## Requirements
- R1: After reset, and from the first clock edge at which `disp_on` is sampled low, every output (`pix_req`, `col_data`, `col_sclk`, `col_eclk`, `line_latch`, `scan_start`, `ac_drive`, `drive_en`) is 0.
- R2: `col_sclk` is high in phases 2 and 3 of each active slot and low otherwise, giving a period of 4 clocks with a 2-clock high pulse and 2*chars pulses per line.
- R3: `pix_req` is high for one clock in phase 0 of each active slot; the `pix_in` value present in that clock appears on `col_data` in phases 1, 2 and 3 of the same slot, so it is stable across the falling edge of `col_sclk`.
- R4: `col_sclk` stays low from the start of the latch pulse until the first slot of the next line.
- R5: `col_eclk` is high exactly while `col_sclk` is high in slots whose index mod 16 equals 15, so it falls once per 16 shift clocks.
- R6: `line_latch` is high for 4 clocks in slot 2*chars, starting at line position 8*chars, the clock in which the last shift clock of the line has fallen.
- R7: A line lasts 8*total clocks and a frame lasts lines lines; position 0 is line 0, slot 0, phase 0.
- R8: `scan_start` is high for the whole of the last line (index lines-1) of every frame.
- R9: With frame index k counted from 0 at enable, `ac_drive` equals bit 0 of k when `cfg_ac_sel` is 0 (toggling every frame) and bit 1 of k when it is 1 (toggling every second frame).
- R10: `drive_en` is 1 from position 0; with `sleep_req` held, it falls at the second frame boundary whose edge samples `sleep_req` high (one to two frames after the request), and returns to 1 at the first frame boundary that samples `sleep_req` low.
- R11: Dropping `disp_on` for a single edge anywhere in a line restarts timing at position 0 when it is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_on | input | 1 | Run enable; low clears all timing |
| cfg_chars | input | 8 | Active characters per row |
| cfg_total | input | 8 | Total characters per row including retrace |
| cfg_lines | input | 9 | Lines per frame |
| cfg_ac_sel | input | 1 | AC-drive period select |
| sleep_req | input | 1 | Sleep request level |
| pix_in | input | 4 | Pixel nibble from fetch unit |
| pix_req | output | 1 | One-clock request for the next nibble |
| col_data | output | 4 | Column data to the drivers |
| col_sclk | output | 1 | Column shift clock |
| col_eclk | output | 1 | Column enable-chain clock |
| line_latch | output | 1 | Line latch pulse |
| scan_start | output | 1 | Row scan start pulse |
| ac_drive | output | 1 | AC-drive frame signal |
| drive_en | output | 1 | Display drive enable |

## Verification
Every output except `col_data` is registered from the next value of the position counters, so it is valid in the same clock as the position it belongs to; the bench numbers clocks from the first enabled edge and samples on the falling clock edge, comparing each output every clock against a formula in the position. `col_data` lags the request by one register, so it is compared only in phases 1 to 3 against the nibble driven in phase 0 of that slot. `drive_en` changes only at the edges that start a frame, so the bench replays the sleep level it drove in the clock before each boundary to decide the expected value.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int unsigned SLOT_CLKS = 4;
  localparam int unsigned EN_GROUP  = 16;

  typedef enum logic [1:0] {
    PH_REQ   = 2'd0,
    PH_DATA  = 2'd1,
    PH_SCK_A = 2'd2,
    PH_SCK_B = 2'd3
  } phase_e;

  typedef struct packed {
    logic req;
    logic sclk;
    logic eclk;
    logic latch;
  } col_ctl_t;

endpackage

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_scan_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              adv,
  input  logic [CHAR_W-1:0] cfg_chars,
  input  logic [CHAR_W-1:0] cfg_total,
  input  logic [DATA_W-1:0] pix_in,
  output logic              line_wrap,
  output col_ctl_t          ctl,
  output logic [DATA_W-1:0] col_data
);

  localparam int SLOT_W = CHAR_W + 1;
  localparam int GRP_W  = $clog2(EN_GROUP);

  phase_e            ph_q, ph_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [SLOT_W-1:0] slot_last, act_end;
  logic              act_n;
  col_ctl_t          ctl_q, ctl_n;
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    slot_last = {cfg_total, 1'b0} - SLOT_W'(1);
    act_end   = {cfg_chars, 1'b0};
    line_wrap = adv && (ph_q == PH_SCK_B) && (slot_q == slot_last);
  end

  // position next state
  always_comb begin
    ph_n   = PH_REQ;
    slot_n = '0;
    if (adv) begin
      if (ph_q == PH_SCK_B) begin
        ph_n   = PH_REQ;
        slot_n = (slot_q == slot_last) ? '0 : slot_q + SLOT_W'(1);
      end else begin
        ph_n   = phase_e'(ph_q + 2'd1);
        slot_n = slot_q;
      end
    end
  end

  // outputs decoded from the next position
  always_comb begin
    act_n      = slot_n < act_end;
    ctl_n.req  = go && act_n && (ph_n == PH_REQ);
    ctl_n.sclk = go && act_n && ((ph_n == PH_SCK_A) || (ph_n == PH_SCK_B));
    ctl_n.eclk = ctl_n.sclk && (slot_n[GRP_W-1:0] == GRP_W'(EN_GROUP - 1));
    ctl_n.latch = go && (slot_n == act_end);
  end

  always_comb begin
    data_n = data_q;
    if (!go) begin
      data_n = '0;
    end else if (ctl_q.req) begin
      data_n = pix_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_REQ;
      slot_q <= '0;
      ctl_q  <= '0;
      data_q <= '0;
    end else begin
      ph_q   <= ph_n;
      slot_q <= slot_n;
      ctl_q  <= ctl_n;
      data_q <= data_n;
    end
  end

  assign ctl      = ctl_q;
  assign col_data = data_q;

  assert_sclk_high_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_q.sclk) && go) |=> ctl_q.sclk);

  assert_sclk_high_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.sclk && $past(ctl_q.sclk)) |=> !ctl_q.sclk);

  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.sclk |-> $stable(data_q));

  assert_latch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.latch |-> !ctl_q.sclk);

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              adv,
  input  logic              line_wrap,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic              cfg_ac_sel,
  output logic              frame_tick,
  output logic              scan_start,
  output logic              ac_drive
);

  localparam int FRM_W = 2;

  logic [LINE_W-1:0] line_q, line_n, line_last;
  logic [FRM_W-1:0]  frm_q, frm_n;
  logic              scan_q, scan_n;
  logic              ac_q, ac_n;

  always_comb begin
    line_last  = cfg_lines - LINE_W'(1);
    frame_tick = line_wrap && (line_q == line_last);
  end

  always_comb begin
    line_n = line_q;
    frm_n  = frm_q;
    if (!adv) begin
      line_n = '0;
      frm_n  = '0;
    end else if (line_wrap) begin
      line_n = frame_tick ? '0 : line_q + LINE_W'(1);
      if (frame_tick) begin
        frm_n = frm_q + FRM_W'(1);
      end
    end
    scan_n = go && (line_n == line_last);
    ac_n   = go && frm_n[cfg_ac_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      frm_q  <= '0;
      scan_q <= 1'b0;
      ac_q   <= 1'b0;
    end else begin
      line_q <= line_n;
      frm_q  <= frm_n;
      scan_q <= scan_n;
      ac_q   <= ac_n;
    end
  end

  assign scan_start = scan_q;
  assign ac_drive   = ac_q;

  assert_ac_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_q != $past(ac_q)) |-> (line_q == '0));

endmodule

// File: rtl/lcd_sleep_ctrl.sv
module lcd_sleep_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic adv,
  input  logic frame_tick,
  input  logic sleep_req,
  output logic drive_en
);

  logic de_q, de_n;
  logic armed_q, armed_n;

  always_comb begin
    de_n    = de_q;
    armed_n = armed_q;
    if (!go) begin
      de_n    = 1'b0;
      armed_n = 1'b0;
    end else if (!adv) begin
      de_n    = 1'b1;
      armed_n = 1'b0;
    end else if (frame_tick) begin
      if (sleep_req) begin
        if (armed_q) begin
          de_n = 1'b0;
        end
        armed_n = 1'b1;
      end else begin
        armed_n = 1'b0;
        de_n    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      de_q    <= de_n;
      armed_q <= armed_n;
    end
  end

  assign drive_en = de_q;

  assert_sleep_two_frames_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(de_q) && $past(go)) |-> $past(armed_q));

  assert_de_frame_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((de_q != $past(de_q)) && $past(adv)) |-> $past(frame_tick));

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LINE_W = 9,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_on,
  input  logic [CHAR_W-1:0] cfg_chars,
  input  logic [CHAR_W-1:0] cfg_total,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic              cfg_ac_sel,
  input  logic              sleep_req,
  input  logic [DATA_W-1:0] pix_in,
  output logic              pix_req,
  output logic [DATA_W-1:0] col_data,
  output logic              col_sclk,
  output logic              col_eclk,
  output logic              line_latch,
  output logic              scan_start,
  output logic              ac_drive,
  output logic              drive_en
);

  logic     rst_meta, rst_sync;
  logic     active_q;
  logic     go, adv;
  logic     line_wrap, frame_tick;
  col_ctl_t ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      active_q <= 1'b0;
    end else begin
      active_q <= disp_on;
    end
  end

  assign go  = disp_on;
  assign adv = disp_on && active_q;

  lcd_line_timer #(
    .CHAR_W (CHAR_W),
    .DATA_W (DATA_W)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_sync),
    .go        (go),
    .adv       (adv),
    .cfg_chars (cfg_chars),
    .cfg_total (cfg_total),
    .pix_in    (pix_in),
    .line_wrap (line_wrap),
    .ctl       (ctl),
    .col_data  (col_data)
  );

  lcd_frame_timer #(
    .LINE_W (LINE_W)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync),
    .go         (go),
    .adv        (adv),
    .line_wrap  (line_wrap),
    .cfg_lines  (cfg_lines),
    .cfg_ac_sel (cfg_ac_sel),
    .frame_tick (frame_tick),
    .scan_start (scan_start),
    .ac_drive   (ac_drive)
  );

  lcd_sleep_ctrl u_sleep (
    .clk        (clk),
    .rst_n      (rst_sync),
    .go         (go),
    .adv        (adv),
    .frame_tick (frame_tick),
    .sleep_req  (sleep_req),
    .drive_en   (drive_en)
  );

  assign pix_req    = ctl.req;
  assign col_sclk   = ctl.sclk;
  assign col_eclk   = ctl.eclk;
  assign line_latch = ctl.latch;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    !$past(disp_on) |-> !(pix_req || col_sclk || col_eclk || line_latch ||
                          scan_start || ac_drive || drive_en || (col_data != '0)));

endmodule

// File: tb/lcd_scan_timer_tb_top.sv
module lcd_scan_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       disp_on;
  logic [7:0] cfg_chars, cfg_total;
  logic [8:0] cfg_lines;
  logic       cfg_ac_sel;
  logic       sleep_req;
  logic [3:0] pix_in;
  logic       pix_req, col_sclk, col_eclk, line_latch, scan_start, ac_drive, drive_en;
  logic [3:0] col_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lcd_scan_timer dut_i (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on),
    .cfg_chars(cfg_chars), .cfg_total(cfg_total), .cfg_lines(cfg_lines),
    .cfg_ac_sel(cfg_ac_sel), .sleep_req(sleep_req), .pix_in(pix_in),
    .pix_req(pix_req), .col_data(col_data), .col_sclk(col_sclk),
    .col_eclk(col_eclk), .line_latch(line_latch), .scan_start(scan_start),
    .ac_drive(ac_drive), .drive_en(drive_en)
  );

  function automatic logic [3:0] pixv(input int p);
    return 4'((p * 5 + p / 7 + 3) & 15);
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input int p);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", tag, p, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R1 pix_req"},    int'(pix_req),    0, -1);
    chk({tag, " R1 col_data"},   int'(col_data),   0, -1);
    chk({tag, " R1 col_sclk"},   int'(col_sclk),   0, -1);
    chk({tag, " R1 col_eclk"},   int'(col_eclk),   0, -1);
    chk({tag, " R1 line_latch"}, int'(line_latch), 0, -1);
    chk({tag, " R1 scan_start"}, int'(scan_start), 0, -1);
    chk({tag, " R1 ac_drive"},   int'(ac_drive),   0, -1);
    chk({tag, " R1 drive_en"},   int'(drive_en),   0, -1);
  endtask

  // Enable at a falling edge; position 0 is the clock after the next rising edge.
  task automatic run_cfg(input int c, input int t, input int n, input int sel,
                         input int ncyc, input int s_on, input int s_off);
    int  l, f;
    bit  slp, de_e, arm_e;
    l = 8 * t;
    f = l * n;
    cfg_chars  = 8'(c);
    cfg_total  = 8'(t);
    cfg_lines  = 9'(n);
    cfg_ac_sel = sel[0];
    disp_on    = 1'b1;
    sleep_req  = 1'b0;
    slp = 1'b0; de_e = 1'b0; arm_e = 1'b0;
    for (int p = 0; p < ncyc; p++) begin
      int  q, s, ph, r, fr;
      bit  act;
      @(negedge clk);
      q   = p % l;
      s   = q / 4;
      ph  = q % 4;
      r   = (p / l) % n;
      fr  = (p / f) % 4;
      act = (s < 2 * c);
      if (p == 0) begin
        de_e = 1'b1; arm_e = 1'b0;
      end else if (p % f == 0) begin
        if (slp) begin
          if (arm_e) de_e = 1'b0;
          arm_e = 1'b1;
        end else begin
          arm_e = 1'b0;
          de_e  = 1'b1;
        end
      end
      chk("R3 pix_req",    int'(pix_req),    int'(act && ph == 0), p);
      chk("R2 col_sclk",   int'(col_sclk),   int'(act && ph >= 2), p);
      chk("R5 col_eclk",   int'(col_eclk),   int'(act && ph >= 2 && (s % 16) == 15), p);
      chk("R6 line_latch", int'(line_latch), int'(s == 2 * c), p);
      chk("R8 scan_start", int'(scan_start), int'(r == n - 1), p);
      chk("R9 ac_drive",   int'(ac_drive),   (fr >> sel) & 1, p);
      chk("R10 drive_en",  int'(drive_en),   int'(de_e), p);
      if (s >= 2 * c) chk("R4 sclk low in retrace", int'(col_sclk), 0, p);
      if (q == 0) chk("R7 line start request", int'(pix_req), 1, p);
      if (act && ph != 0) chk("R3 col_data", int'(col_data), int'(pixv(p - ph)), p);
      pix_in = pixv(p);
      if (p == s_on)  slp = 1'b1;
      if (p == s_off) slp = 1'b0;
      sleep_req = slp;
    end
    disp_on   = 1'b0;
    sleep_req = 1'b0;
    @(negedge clk);
    chk_idle("disable R11");
  endtask

  initial begin
    rst_n = 1'b0; disp_on = 1'b0; sleep_req = 1'b0; pix_in = 4'd0;
    cfg_chars = 8'd3; cfg_total = 8'd5; cfg_lines = 9'd4; cfg_ac_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("reset");
    // R11: partial line, one-edge gap, then full restart from position 0
    run_cfg(3, 5, 4, 0, 100, -1, -1);
    run_cfg(3, 5, 4, 0, 3 * 160, -1, -1);
    // R5, R9 (sel 1), R10 sleep enter and leave
    run_cfg(17, 18, 3, 1, 6 * 432, 500, 1400);
    // minimal geometry, retrace of one character
    run_cfg(1, 2, 2, 0, 200, -1, -1);
    // sleep requested right before a boundary: falls one frame later
    run_cfg(2, 3, 2, 1, 8 * 48, 46, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule